// File: doc/BRIEF.md
# Sync Request and Error Pulse Discriminator

This block watches the active-low synchronization line that a converter device drives back to a transmitter. A low level on that line has two meanings: a long low level asks the transmitter to resynchronize the link, and a short low pulse reports an error. The block brings the line into the link clock domain, where each cycle carries four octets. It measures how long each low excursion lasts and sorts it into one of the two kinds.

From that sorting it derives three results. The first is a clean active-low request output that only ever shows real resynchronization requests. Software can also force this output low with a dedicated input. The second is a one-cycle error pulse together with a saturating 8-bit count of error reports. The third is a sticky interrupt that is raised by the event types its enable mask admits.

The frame size in octets is a run-time input. The request threshold follows it, so the same instance can serve links with different framing.

Top module: `syncline_classifier`

## Requirements
- R1: While `rst_n` is low, `dev_sync_n` is 1, `irq` is 0, `err_pulse` is 0 and `err_count` is 0, whatever `sync_line_n` and `sw_sync` do.
- R2: The request threshold T in link cycles is ceil((5×F+9)/4), where F is `frame_octets`. F is clamped to the range 1..256, and a new F takes effect once it has been stable for two cycles.
- R3: A low excursion is first sampled low on clock edge k and first sampled high on edge m. If it lasts T or more cycles, `dev_sync_n` goes to 0 after edge k+T+1 and returns to 1 after edge m+2. No error pulse follows.
- R4: A low excursion of 1 to T-1 cycles leaves `dev_sync_n` at 1. It produces exactly one one-cycle `err_pulse`, which is high after edge m+2.
- R5: `err_count` rises by one with each error pulse. It is unchanged by request excursions and saturates at 255.
- R6: `cnt_clr` high at a clock edge sets `err_count` to 0 at that edge.
- R7: `dev_sync_n` is 0 after every edge at which `sw_sync` is high. Once `sw_sync` has fallen and the line is idle, it is 1 again after the next edge.
- R8: `irq` is set after the edge where an error is sorted, if `irq_en` bit 0 is set. It is also set after the edge where `dev_sync_n` first falls for a request, if `irq_en` bit 1 is set. Once set, it stays high after its cause is gone. A masked event type leaves it at 0.
- R9: `irq_clr` high at an edge with no new enabled event clears `irq` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock, four octets per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_line_n | input | 1 | Asynchronous active-low sync line from the converter |
| sw_sync | input | 1 | Software-initiated sync; forces the clean request low |
| frame_octets | input | 9 | Octets per frame F (1..256) |
| cnt_clr | input | 1 | Synchronous clear of the error counter |
| irq_en | input | 2 | Interrupt enable mask: bit 0 errors, bit 1 requests |
| irq_clr | input | 1 | Clears the sticky interrupt |
| dev_sync_n | output | 1 | Clean active-low sync request |
| err_pulse | output | 1 | One-cycle error report pulse |
| err_count | output | 8 | Saturating count of error reports |
| irq | output | 1 | Sticky interrupt |

## Verification
Each line excursion starts one cycle before a clock edge, and the bench samples every output at the falling clock edge. Each sample is indexed by the rising edge that came before it. The two synchronizer flops, the run counter and the output register place the fall of the request output at index T+2. Its release comes at excursion length plus 3, and the error pulse, counter step and error interrupt all appear at excursion length plus 3. The request interrupt appears at T+2. The scenario tasks compare the exact sample index of every edge of the outputs against those figures. They test exactly T-1 and T cycles for several frame sizes, including an exact multiple of four and the largest frame.

// File: rtl/syncline_pkg.sv
package syncline_pkg;
   // Interrupt source positions inside the enable mask
   localparam int unsigned SRC_ERR = 0;
   localparam int unsigned SRC_REQ = 1;
   localparam int unsigned N_SRC   = 2;

   // Request threshold in link cycles for a frame of f octets
   function automatic int unsigned thr_cycles(input int unsigned f, input int unsigned opc);
      return (5 * f + 9 + opc - 1) / opc;
   endfunction
endpackage

// File: rtl/sc_sync2.sv
module sc_sync2 #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sc_sync2: STAGES must be at least 2");
   end

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/sc_threshold.sv
module sc_threshold #(
   parameter int unsigned F_W     = 9,
   parameter int unsigned F_MAX   = 256,
   parameter int unsigned OPC     = 4,
   parameter int unsigned RUN_W   = 9,
   parameter int unsigned THR_RST = 323
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [F_W-1:0]   f_octets,
   output logic [RUN_W-1:0] thr
);
   localparam int unsigned OCT_W = F_W + 4;
   localparam logic [F_W-1:0] F_TOP = F_W'(F_MAX);
   localparam logic [OCT_W-1:0] ROUND_ADD = OCT_W'(9 + OPC - 1);

   if (F_MAX >= (1 << F_W)) begin : g_bad_fmax
      $error("sc_threshold: F_MAX does not fit in F_W bits");
   end

   logic [F_W-1:0]   f_eff;
   logic [OCT_W-1:0] f_wide;
   logic [OCT_W-1:0] octets;
   logic [RUN_W-1:0] thr_d;

   // Clamp frame size into the legal range
   always_comb begin
      if (f_octets == '0)        f_eff = F_W'(1);
      else if (f_octets > F_TOP) f_eff = F_TOP;
      else                       f_eff = f_octets;
   end

   assign f_wide = {4'b0000, f_eff};
   assign octets = (f_wide << 2) + f_wide + ROUND_ADD;

   // Rounding-up divide: a shift when OPC is a power of two
   if ((OPC & (OPC - 1)) == 0) begin : g_shift
      localparam int unsigned SH = $clog2(OPC);
      logic [OCT_W-1:0] q_shift;
      assign q_shift = octets >> SH;
      assign thr_d   = q_shift[RUN_W-1:0];
   end else begin : g_divide
      logic [OCT_W-1:0] q_div;
      assign q_div = octets / OCT_W'(OPC);
      assign thr_d = q_div[RUN_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) thr <= RUN_W'(THR_RST);
      else        thr <= thr_d;
   end
endmodule

// File: rtl/sc_excursion.sv
module sc_excursion #(
   parameter int unsigned RUN_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_s,
   input  logic [RUN_W-1:0] thr,
   output logic             reached,
   output logic             req_det,
   output logic             err_det
);
   logic [RUN_W-1:0] run_q;
   logic [RUN_W-1:0] run_d;
   logic             req_q;

   // Count low cycles, holding once the threshold is met
   always_comb begin
      if (line_s)          run_d = '0;
      else if (run_q >= thr) run_d = run_q;
      else                 run_d = run_q + 1'b1;
   end

   assign reached = !line_s && (run_d >= thr);
   assign req_det = reached && !req_q;
   assign err_det = line_s && (run_q != '0) && (run_q < thr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= '0;
         req_q <= 1'b0;
      end else begin
         run_q <= run_d;
         req_q <= reached;
      end
   end
endmodule

// File: rtl/sc_err_counter.sv
module sc_err_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)                       count <= '0;
      else if (clr)                     count <= '0;
      else if (inc && count != CNT_MAX) count <= count + 1'b1;
   end
endmodule

// File: rtl/sc_irq_latch.sv
module sc_irq_latch #(
   parameter int unsigned N_SRC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt,
   input  logic [N_SRC-1:0] en,
   input  logic             clr,
   output logic             irq
);
   logic hit;
   assign hit = |(evt & en);

   // A new enabled event wins over a clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n)   irq <= 1'b0;
      else if (hit) irq <= 1'b1;
      else if (clr) irq <= 1'b0;
   end
endmodule

// File: rtl/syncline_classifier.sv
module syncline_classifier
   import syncline_pkg::*;
#(
   parameter int unsigned OPC         = 4,
   parameter int unsigned F_W         = 9,
   parameter int unsigned F_MAX       = 256,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_line_n,
   input  logic             sw_sync,
   input  logic [F_W-1:0]   frame_octets,
   input  logic             cnt_clr,
   input  logic [N_SRC-1:0] irq_en,
   input  logic             irq_clr,
   output logic             dev_sync_n,
   output logic             err_pulse,
   output logic [CNT_W-1:0] err_count,
   output logic             irq
);
   localparam int unsigned THR_MAX = thr_cycles(F_MAX, OPC);
   localparam int unsigned RUN_W   = $clog2(THR_MAX + 1);

   if (OPC < 1) begin : g_bad_opc
      $error("syncline_classifier: OPC must be at least 1");
   end
   if (F_MAX < 1) begin : g_bad_fmax
      $error("syncline_classifier: F_MAX must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("syncline_classifier: CNT_W must be at least 1");
   end

   logic             line_s;
   logic [RUN_W-1:0] thr;
   logic             reached;
   logic             req_det;
   logic             err_det;
   logic [N_SRC-1:0] evt;

   sc_sync2 #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(sync_line_n), .q(line_s)
   );

   sc_threshold #(
      .F_W(F_W), .F_MAX(F_MAX), .OPC(OPC), .RUN_W(RUN_W), .THR_RST(THR_MAX)
   ) u_thr (
      .clk(clk), .rst_n(rst_n), .f_octets(frame_octets), .thr(thr)
   );

   sc_excursion #(.RUN_W(RUN_W)) u_exc (
      .clk(clk), .rst_n(rst_n), .line_s(line_s), .thr(thr),
      .reached(reached), .req_det(req_det), .err_det(err_det)
   );

   sc_err_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(err_det), .clr(cnt_clr), .count(err_count)
   );

   always_comb begin
      evt          = '0;
      evt[SRC_ERR] = err_det;
      evt[SRC_REQ] = req_det;
   end

   sc_irq_latch #(.N_SRC(N_SRC)) u_irq (
      .clk(clk), .rst_n(rst_n), .evt(evt), .en(irq_en), .clr(irq_clr), .irq(irq)
   );

   // Registered outputs: request masked of error pulses, software override
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dev_sync_n <= 1'b1;
         err_pulse  <= 1'b0;
      end else begin
         dev_sync_n <= !(reached || sw_sync);
         err_pulse  <= err_det;
      end
   end
endmodule

// File: rtl/syncline_classifier_chk.sv
module syncline_classifier_chk #(
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sw_sync,
   input logic             cnt_clr,
   input logic             irq_clr,
   input logic             dev_sync_n,
   input logic             err_pulse,
   input logic [CNT_W-1:0] err_count,
   input logic             irq
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   // R4: an error report lasts exactly one cycle
   assert_err_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |=> !err_pulse);

   // R5: the counter only moves upward by one, together with an error pulse
   assert_cnt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count != $past(err_count) && !$past(cnt_clr))
         |-> (err_pulse && err_count == $past(err_count) + 1'b1));

   // R5: saturation holds the count
   assert_cnt_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (err_count == CNT_MAX && !cnt_clr) |=> err_count == CNT_MAX);

   // R6: clear empties the counter
   assert_cnt_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_clr |=> err_count == '0);

   // R7: software sync forces the request low
   assert_sw_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sw_sync |=> !dev_sync_n);

   // R8: the interrupt is sticky until cleared
   assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);
endmodule

bind syncline_classifier syncline_classifier_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sw_sync(sw_sync), .cnt_clr(cnt_clr),
   .irq_clr(irq_clr), .dev_sync_n(dev_sync_n), .err_pulse(err_pulse),
   .err_count(err_count), .irq(irq)
);

// File: tb/syncline_classifier_test.sv
module syncline_classifier_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_line_n = 1'b1;
   logic       sw_sync = 1'b0;
   logic [8:0] frame_octets = 9'd1;
   logic       cnt_clr = 1'b0;
   logic [1:0] irq_en = 2'b00;
   logic       irq_clr = 1'b0;
   logic       dev_sync_n;
   logic       err_pulse;
   logic [7:0] err_count;
   logic       irq;

   int checks = 0;
   int errors = 0;
   int first_low, last_low, low_cnt, ep_cnt, ep_idx, irq_idx;

   always #2 clk = ~clk;

   syncline_classifier uut (
      .clk(clk), .rst_n(rst_n), .sync_line_n(sync_line_n), .sw_sync(sw_sync),
      .frame_octets(frame_octets), .cnt_clr(cnt_clr), .irq_en(irq_en),
      .irq_clr(irq_clr), .dev_sync_n(dev_sync_n), .err_pulse(err_pulse),
      .err_count(err_count), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int thr_of(input int f);
      return (5 * f + 9 + 3) / 4;
   endfunction

   // Drive one low excursion of len edges and record output timing
   task automatic run_pulse(input int len);
      first_low = -1; last_low = -1; low_cnt = 0; ep_cnt = 0; ep_idx = -1; irq_idx = -1;
      @(negedge clk);
      sync_line_n = 1'b0;
      for (int i = 1; i <= len + 8; i++) begin
         @(negedge clk);
         if (!dev_sync_n) begin
            if (first_low < 0) first_low = i;
            last_low = i;
            low_cnt++;
         end
         if (err_pulse) begin ep_cnt++; ep_idx = i; end
         if (irq && irq_idx < 0) irq_idx = i;
         if (i == len) sync_line_n = 1'b1;
      end
   endtask

   task automatic set_f(input int f);
      @(negedge clk);
      frame_octets = 9'(f);
      repeat (3) @(negedge clk);
   endtask

   task automatic pulse_irq_clr();
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
   endtask

   task automatic t_reset();
      sync_line_n = 1'b0; sw_sync = 1'b1;
      repeat (4) @(negedge clk);
      chk(dev_sync_n == 1'b1, "R1", "dev_sync_n in reset", int'(dev_sync_n), 1);
      chk(irq == 1'b0, "R1", "irq in reset", int'(irq), 0);
      chk(err_pulse == 1'b0, "R1", "err_pulse in reset", int'(err_pulse), 0);
      chk(err_count == 8'd0, "R1", "err_count in reset", int'(err_count), 0);
      sync_line_n = 1'b1; sw_sync = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(dev_sync_n == 1'b1, "R1", "dev_sync_n after reset", int'(dev_sync_n), 1);
   endtask

   task automatic t_boundary(input int f);
      int t;
      t = thr_of(f);
      set_f(f);
      run_pulse(t - 1);
      chk(low_cnt == 0, "R4", "request low for T-1", low_cnt, 0);
      chk(ep_cnt == 1, "R4", "error pulses for T-1", ep_cnt, 1);
      chk(ep_idx == t + 2, "R4", "error pulse index", ep_idx, t + 2);
      run_pulse(t);
      chk(first_low == t + 2, "R2", "request fall index at T", first_low, t + 2);
      chk(low_cnt == 1, "R3", "request length at T", low_cnt, 1);
      chk(ep_cnt == 0, "R3", "no error pulse at T", ep_cnt, 0);
      run_pulse(t + 5);
      chk(first_low == t + 2, "R3", "request fall index", first_low, t + 2);
      chk(last_low == t + 7, "R3", "request release index", last_low, t + 7);
      chk(ep_cnt == 0, "R3", "no error pulse long", ep_cnt, 0);
   endtask

   task automatic t_min_error();
      set_f(8);
      run_pulse(1);
      chk(ep_idx == 4 && ep_cnt == 1, "R4", "one-cycle excursion error index", ep_idx, 4);
      chk(low_cnt == 0, "R4", "one-cycle excursion request", low_cnt, 0);
   endtask

   task automatic t_counter();
      @(negedge clk); cnt_clr = 1'b1;
      @(negedge clk); cnt_clr = 1'b0;
      chk(err_count == 8'd0, "R6", "count after clear", int'(err_count), 0);
      set_f(1);
      for (int n = 0; n < 3; n++) run_pulse(2);
      chk(err_count == 8'd3, "R5", "count after three errors", int'(err_count), 3);
      run_pulse(thr_of(1) + 2);
      chk(err_count == 8'd3, "R5", "count after request", int'(err_count), 3);
      for (int n = 0; n < 260; n++) run_pulse(1);
      chk(err_count == 8'd255, "R5", "count saturates", int'(err_count), 255);
      @(negedge clk); cnt_clr = 1'b1;
      @(negedge clk); cnt_clr = 1'b0;
      chk(err_count == 8'd0, "R6", "count cleared from 255", int'(err_count), 0);
   endtask

   task automatic t_sw();
      @(negedge clk); sw_sync = 1'b1;
      @(negedge clk);
      chk(dev_sync_n == 1'b0, "R7", "software sync low", int'(dev_sync_n), 0);
      repeat (3) @(negedge clk);
      chk(dev_sync_n == 1'b0, "R7", "software sync held", int'(dev_sync_n), 0);
      sw_sync = 1'b0;
      @(negedge clk);
      chk(dev_sync_n == 1'b1, "R7", "software sync release", int'(dev_sync_n), 1);
      chk(err_pulse == 1'b0 && err_count == 8'd0, "R7", "no error from software", int'(err_count), 0);
   endtask

   task automatic t_irq();
      int t;
      set_f(4);
      t = thr_of(4);
      irq_en = 2'b01;
      pulse_irq_clr();
      run_pulse(t);
      chk(irq_idx == -1, "R8", "masked request irq", irq_idx, -1);
      run_pulse(1);
      chk(irq_idx == 4, "R8", "error irq index", irq_idx, 4);
      repeat (5) @(negedge clk);
      chk(irq == 1'b1, "R8", "irq sticky", int'(irq), 1);
      pulse_irq_clr();
      chk(irq == 1'b0, "R9", "irq cleared", int'(irq), 0);
      irq_en = 2'b10;
      run_pulse(2);
      chk(irq_idx == -1, "R8", "masked error irq", irq_idx, -1);
      run_pulse(t + 3);
      chk(irq_idx == t + 2, "R8", "request irq index", irq_idx, t + 2);
      pulse_irq_clr();
      chk(irq == 1'b0, "R9", "irq cleared after request", int'(irq), 0);
      irq_en = 2'b00;
   endtask

   initial begin
      t_reset();
      t_boundary(1);
      t_boundary(3);
      t_boundary(8);
      t_boundary(256);
      t_min_error();
      t_counter();
      t_sw();
      t_irq();
      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule